// File: doc/BRIEF.md
# Dual/Cascaded Conversion Slot Sequencer

This block steps the slot pointer of an analog-to-digital autoconversion engine. It either runs as two independent sequencers of eight slots each (sequencer A on slots 0 to 7, sequencer B on slots 8 to 15) or as one combined sequencer over all sixteen slots. Start triggers from software, an external pin and two PWM event lines are gated by enable bits and routed to a sequencer according to the mode. The active sequencer issues one conversion request per slot and waits for the converter to report completion before it moves on.

Each sequencer has a programmed maximum-conversion count, and its end of sequence is the slot at its base plus that count. Three policies decide what happens there. In start-stop mode the sequencer halts and picks up at the following slot on its next trigger. In continuous mode it goes back to its base slot. In continuous mode with the override bit set it runs on and only wraps at the last physical slot of its range. A reset strobe per sequencer aborts any run and parks the sequencer at its base slot.

The request side is a valid/ready pair. While `req_valid` is high and `req_ready` is low, the block holds the request and `slot_idx` unchanged. One conversion is accepted on the cycle where both are high. The converter then answers with a single-cycle `conv_done` pulse, and the block issues no new request until that pulse arrives.

Top module: `adc_seq_top`

## Requirements
- R1: After reset both sequencers are idle: `busy_a`=0, `busy_b`=0, `req_valid`=0, `eos_a`=`eos_b`=0, `slot_idx`=0.
- R2: In dual mode (`cfg_cascade`=0), sequencer A starts at slot 0 and sequencer B at slot 8. A trigger seen by an idle sequencer at a clock edge makes `req_valid`=1 and the busy flag 1 from that edge, with `slot_idx` at the pointer. B's requests always carry slots 8 to 15.
- R3: While `req_valid`=1 and `req_ready`=0, `req_valid` and `slot_idx` hold. After acceptance there is no further request until `conv_done`.
- R4: The sequencer reaches end of sequence when `conv_done` arrives for slot base+max (max is `max_a`, `max_b` or `max_casc`). Its `eos_a`/`eos_b` output then pulses for exactly one cycle. In start-stop mode (`cfg_continuous`=0) it goes idle. Its pointer moves to the next slot, wrapping at the last physical slot to the base, and the next trigger resumes there.
- R5: In continuous mode with `cfg_override`=0, end of sequence sends the pointer back to the base slot and the next request follows at once, with busy still 1.
- R6: In continuous mode with `cfg_override`=1, the pointer passes base+max without wrapping. It wraps only after slot 7 (A, to 0), slot 15 (B, to 8) or slot 15 (combined, to 0).
- R7: A reset strobe (`seq_rst_a`, `seq_rst_b`) makes that sequencer idle from the next cycle with no request. It puts the sequencer's pointer at its base slot and drops its pending trigger.
- R8: With `cfg_cascade`=1 there is one sequencer over slots 0 to 15 with a 4-bit maximum. It reports through `busy_a`/`eos_a` and is started by A's sources and reset by `seq_rst_a`. `sw_trig_b`, `seq_rst_b` and B's PWM source have no effect, and `busy_b` stays 0.
- R9: Trigger routing: A takes `sw_trig_a`, `ext_trig` when `en_ext_a`=1, and `pwm_trig_a` when `en_pwma_a`=1. B takes `sw_trig_b`, and `pwm_trig_b` when `en_pwmb_b`=1. `pwm_trig_b` reaches the combined sequencer only when `en_pwmb_casc`=1 and cascade is on. In dual mode `en_pwmb_casc` has no effect.
- R10: Only one sequencer holds the converter at a time. When both want to start, A goes first. A trigger seen while the other sequencer (or itself) is running is latched and served once the converter is free.
- R11: A change of `cfg_cascade` makes both sequencers idle from the next cycle, with their pointers at their base slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cascade | input | 1 | 1: one combined 16-slot sequencer |
| cfg_continuous | input | 1 | 1: continuous run, 0: start-stop |
| cfg_override | input | 1 | 1: wrap only at last physical slot (continuous mode) |
| max_a | input | 3 | Maximum-conversion count, sequencer A |
| max_b | input | 3 | Maximum-conversion count, sequencer B |
| max_casc | input | 4 | Maximum-conversion count, combined sequencer |
| sw_trig_a | input | 1 | Software start strobe for A / combined |
| sw_trig_b | input | 1 | Software start strobe for B |
| ext_trig | input | 1 | External start pin |
| pwm_trig_a | input | 1 | PWM event line A |
| pwm_trig_b | input | 1 | PWM event line B |
| en_ext_a | input | 1 | Enable external start for A / combined |
| en_pwma_a | input | 1 | Enable PWM line A for A / combined |
| en_pwmb_b | input | 1 | Enable PWM line B for B (dual mode) |
| en_pwmb_casc | input | 1 | Enable PWM line B for combined sequencer |
| seq_rst_a | input | 1 | Reset strobe, A / combined |
| seq_rst_b | input | 1 | Reset strobe, B (dual mode) |
| req_valid | output | 1 | Conversion request valid |
| req_ready | input | 1 | Converter accepts the request |
| slot_idx | output | 4 | Slot of the owning sequencer, or A's pointer when idle |
| conv_done | input | 1 | Conversion finished pulse |
| busy_a | output | 1 | A (or combined) holds the converter |
| busy_b | output | 1 | B holds the converter |
| eos_a | output | 1 | End-of-sequence pulse, A / combined |
| eos_b | output | 1 | End-of-sequence pulse, B |

## Verification
Every result is due one clock after the stimulus that causes it:

- A trigger sampled at an edge shows up as `req_valid` and busy in the following cycle.
- A `conv_done` sampled at an edge shows up as the end-of-sequence pulse and the next slot in the following cycle.
- Reset strobes and cascade changes idle the sequencer in the following cycle.
- A pending trigger is granted one cycle after the converter becomes free.

The bench drives inputs and samples outputs on the falling edge. Its behavioural model advances on the rising edge from the same inputs and is compared with the outputs on every falling edge. Directed checks read the outputs at the falling edge right after the edge on which each result is due.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_A    = 2'd1,
    OWN_B    = 2'd2
  } owner_e;

  typedef enum logic {
    PH_REQ  = 1'b0,
    PH_WAIT = 1'b1
  } phase_e;
endpackage

// File: rtl/adc_seq_trig.sv
module adc_seq_trig (
  input  logic cascade,
  input  logic sw_a,
  input  logic sw_b,
  input  logic ext_in,
  input  logic pwm_a,
  input  logic pwm_b,
  input  logic en_ext_a,
  input  logic en_pwma_a,
  input  logic en_pwmb_b,
  input  logic en_pwmb_casc,
  output logic [1:0] trig
);
  logic common_a;

  always_comb begin
    common_a = sw_a | (ext_in & en_ext_a) | (pwm_a & en_pwma_a);
    if (cascade) begin
      trig[0] = common_a | (pwm_b & en_pwmb_casc);
      trig[1] = 1'b0;
    end else begin
      trig[0] = common_a;
      trig[1] = sw_b | (pwm_b & en_pwmb_b);
    end
  end
endmodule

// File: rtl/adc_seq_step.sv
module adc_seq_step #(
  parameter int SW   = 4,
  parameter int MW   = 3,
  parameter int BASE = 0,
  parameter int LAST = 7
) (
  input  logic [SW-1:0] ptr,
  input  logic [MW-1:0] max_cnt,
  input  logic          continuous,
  input  logic          override,
  output logic          eos,
  output logic          run_on,
  output logic [SW-1:0] nxt
);
  localparam logic [SW-1:0] BASE_V = SW'(BASE);
  localparam logic [SW-1:0] LAST_V = SW'(LAST);

  logic [SW-1:0] end_slot;
  logic [SW-1:0] inc;

  always_comb begin
    end_slot = BASE_V + SW'(max_cnt);
    inc      = (ptr == LAST_V) ? BASE_V : ptr + SW'(1);
    eos      = (ptr == end_slot);
    run_on   = !eos || continuous;
    if (eos && continuous && !override) nxt = BASE_V;
    else                                nxt = inc;
  end
endmodule

// File: rtl/adc_seq_pend.sv
module adc_seq_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic take_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_o <= 1'b0;
    else if (clr_i)  pend_o <= 1'b0;
    else if (take_i) pend_o <= 1'b0;
    else if (set_i)  pend_o <= 1'b1;
  end
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int SEQ_SLOTS = 8,
  localparam int SW = $clog2(2 * SEQ_SLOTS),
  localparam int MW = $clog2(SEQ_SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_cascade,
  input  logic          cfg_continuous,
  input  logic          cfg_override,
  input  logic [MW-1:0] max_a,
  input  logic [MW-1:0] max_b,
  input  logic [SW-1:0] max_casc,
  input  logic          sw_trig_a,
  input  logic          sw_trig_b,
  input  logic          ext_trig,
  input  logic          pwm_trig_a,
  input  logic          pwm_trig_b,
  input  logic          en_ext_a,
  input  logic          en_pwma_a,
  input  logic          en_pwmb_b,
  input  logic          en_pwmb_casc,
  input  logic          seq_rst_a,
  input  logic          seq_rst_b,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [SW-1:0] slot_idx,
  input  logic          conv_done,
  output logic          busy_a,
  output logic          busy_b,
  output logic          eos_a,
  output logic          eos_b
);
  localparam logic [SW-1:0] BASE_A = '0;
  localparam logic [SW-1:0] BASE_B = SW'(SEQ_SLOTS);

  owner_e        owner_q;
  phase_e        phase_q;
  logic [SW-1:0] ptr_q [2];
  logic [1:0]    eos_q;
  logic          casc_q;

  logic [1:0]    trig, pend, clr, want, start;
  logic [MW-1:0] max_dual [2];
  logic [1:0]    d_eos, d_run;
  logic [SW-1:0] d_nxt [2];
  logic          c_eos, c_run;
  logic [SW-1:0] c_nxt;
  logic          mode_chg, free, abort;
  logic          own_eos, own_run;
  logic [SW-1:0] own_nxt;
  logic          oi;

  adc_seq_trig u_trig (
    .cascade(cfg_cascade), .sw_a(sw_trig_a), .sw_b(sw_trig_b),
    .ext_in(ext_trig), .pwm_a(pwm_trig_a), .pwm_b(pwm_trig_b),
    .en_ext_a(en_ext_a), .en_pwma_a(en_pwma_a), .en_pwmb_b(en_pwmb_b),
    .en_pwmb_casc(en_pwmb_casc), .trig(trig)
  );

  assign max_dual[0] = max_a;
  assign max_dual[1] = max_b;

  for (genvar g = 0; g < 2; g++) begin : g_seq
    adc_seq_step #(
      .SW(SW), .MW(MW),
      .BASE(g * SEQ_SLOTS), .LAST(g * SEQ_SLOTS + SEQ_SLOTS - 1)
    ) u_step (
      .ptr(ptr_q[g]), .max_cnt(max_dual[g]),
      .continuous(cfg_continuous), .override(cfg_override),
      .eos(d_eos[g]), .run_on(d_run[g]), .nxt(d_nxt[g])
    );

    adc_seq_pend u_pend (
      .clk(clk), .rst_n(rst_n), .set_i(trig[g]),
      .take_i(start[g]), .clr_i(clr[g]), .pend_o(pend[g])
    );
  end

  adc_seq_step #(
    .SW(SW), .MW(SW), .BASE(0), .LAST(2 * SEQ_SLOTS - 1)
  ) u_casc_step (
    .ptr(ptr_q[0]), .max_cnt(max_casc),
    .continuous(cfg_continuous), .override(cfg_override),
    .eos(c_eos), .run_on(c_run), .nxt(c_nxt)
  );

  always_comb begin
    mode_chg = cfg_cascade ^ casc_q;
    clr[0]   = mode_chg | seq_rst_a;
    clr[1]   = mode_chg | (seq_rst_b & ~cfg_cascade);
    want     = pend | trig;
    free     = (owner_q == OWN_NONE);
    start[0] = free & want[0] & ~clr[0];
    start[1] = free & ~start[0] & ~(want[0] & ~clr[0]) & want[1] & ~clr[1] & ~cfg_cascade;
    abort    = ((owner_q == OWN_A) & clr[0]) | ((owner_q == OWN_B) & clr[1]);
    oi       = (owner_q == OWN_B);
    if (owner_q == OWN_B) begin
      own_eos = d_eos[1]; own_run = d_run[1]; own_nxt = d_nxt[1];
    end else if (cfg_cascade) begin
      own_eos = c_eos;    own_run = c_run;    own_nxt = c_nxt;
    end else begin
      own_eos = d_eos[0]; own_run = d_run[0]; own_nxt = d_nxt[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q  <= OWN_NONE;
      phase_q  <= PH_REQ;
      ptr_q[0] <= BASE_A;
      ptr_q[1] <= BASE_B;
      eos_q    <= '0;
      casc_q   <= 1'b0;
    end else begin
      casc_q <= cfg_cascade;
      eos_q  <= '0;
      if (abort) begin
        owner_q <= OWN_NONE;
        phase_q <= PH_REQ;
      end else if (free) begin
        phase_q <= PH_REQ;
        if (start[0])      owner_q <= OWN_A;
        else if (start[1]) owner_q <= OWN_B;
      end else if (phase_q == PH_REQ) begin
        if (req_ready) phase_q <= PH_WAIT;
      end else if (conv_done) begin
        ptr_q[oi] <= own_nxt;
        eos_q[oi] <= own_eos;
        phase_q   <= PH_REQ;
        if (!own_run) owner_q <= OWN_NONE;
      end
      if (clr[0]) ptr_q[0] <= BASE_A;
      if (clr[1]) ptr_q[1] <= BASE_B;
    end
  end

  assign req_valid = (owner_q != OWN_NONE) && (phase_q == PH_REQ);
  assign slot_idx  = (owner_q == OWN_B) ? ptr_q[1] : ptr_q[0];
  assign busy_a    = (owner_q == OWN_A);
  assign busy_b    = (owner_q == OWN_B);
  assign eos_a     = eos_q[0];
  assign eos_b     = eos_q[1];
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int SW = 4,
  parameter int SEQ_SLOTS = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_cascade,
  input logic          seq_rst_a,
  input logic          seq_rst_b,
  input logic          req_valid,
  input logic          req_ready,
  input logic [SW-1:0] slot_idx,
  input logic          busy_a,
  input logic          busy_b,
  input logic          eos_a,
  input logic          eos_b
);
  logic casc_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) casc_seen <= 1'b0;
    else        casc_seen <= cfg_cascade;
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !seq_rst_a && !seq_rst_b && (cfg_cascade == casc_seen))
    |=> (req_valid && $stable(slot_idx)));

  // R10
  one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_a && busy_b));

  // R4
  eos_a_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eos_a |=> !eos_a);

  // R4
  eos_b_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eos_b |=> !eos_b);

  // R7
  rst_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_rst_a && busy_a) |=> (!busy_a && !req_valid));

  // R8
  casc_b_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cascade && casc_seen) |-> (!busy_b && !eos_b));

  // R2
  b_slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_b && req_valid) |-> (slot_idx >= SW'(SEQ_SLOTS)));
endmodule

bind adc_seq_top adc_seq_chk #(.SW(SW), .SEQ_SLOTS(SEQ_SLOTS)) i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_cascade(cfg_cascade),
  .seq_rst_a(seq_rst_a), .seq_rst_b(seq_rst_b),
  .req_valid(req_valid), .req_ready(req_ready), .slot_idx(slot_idx),
  .busy_a(busy_a), .busy_b(busy_b), .eos_a(eos_a), .eos_b(eos_b)
);

// File: tb/test_adc_seq_top.sv
module test_adc_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_cascade = 0, cfg_continuous = 0, cfg_override = 0;
  logic [2:0] max_a = 3'd2, max_b = 3'd1;
  logic [3:0] max_casc = 4'd0;
  logic sw_trig_a = 0, sw_trig_b = 0, ext_trig = 0, pwm_trig_a = 0, pwm_trig_b = 0;
  logic en_ext_a = 0, en_pwma_a = 0, en_pwmb_b = 0, en_pwmb_casc = 0;
  logic seq_rst_a = 0, seq_rst_b = 0;
  logic req_ready, conv_done;
  logic req_valid, busy_a, busy_b, eos_a, eos_b;
  logic [3:0] slot_idx;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit bp = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_top i_adc_seq_top (
    .clk(clk), .rst_n(rst_n), .cfg_cascade(cfg_cascade),
    .cfg_continuous(cfg_continuous), .cfg_override(cfg_override),
    .max_a(max_a), .max_b(max_b), .max_casc(max_casc),
    .sw_trig_a(sw_trig_a), .sw_trig_b(sw_trig_b), .ext_trig(ext_trig),
    .pwm_trig_a(pwm_trig_a), .pwm_trig_b(pwm_trig_b),
    .en_ext_a(en_ext_a), .en_pwma_a(en_pwma_a), .en_pwmb_b(en_pwmb_b),
    .en_pwmb_casc(en_pwmb_casc), .seq_rst_a(seq_rst_a), .seq_rst_b(seq_rst_b),
    .req_valid(req_valid), .req_ready(req_ready), .slot_idx(slot_idx),
    .conv_done(conv_done), .busy_a(busy_a), .busy_b(busy_b),
    .eos_a(eos_a), .eos_b(eos_b)
  );

  // converter stub: fixed latency, optional back-pressure
  int cnt;
  logic [7:0] lfsr;
  always @(posedge clk) begin
    if (!rst_n) begin
      cnt <= 0; conv_done <= 0; req_ready <= 1; lfsr <= 8'hA5;
    end else begin
      conv_done <= (cnt == 1);
      if (req_valid && req_ready) cnt <= LAT;
      else if (cnt != 0)          cnt <= cnt - 1;
      lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      req_ready <= bp ? lfsr[0] : 1'b1;
    end
  end

  // behavioural reference model
  int m_own;  // 0 none, 1 A/combined, 2 B
  bit m_wait, m_qa, m_qb, m_cq, m_ea, m_eb;
  int m_pa, m_pb;
  always @(posedge clk) begin : model
    bit chg, ta, tb, ca, cb, take_a, take_b, at_end;
    int o_own, base, last, endp, p, np;
    if (!rst_n) begin
      m_own = 0; m_wait = 0; m_qa = 0; m_qb = 0; m_cq = 0;
      m_ea = 0; m_eb = 0; m_pa = 0; m_pb = 8;
    end else begin
      chg = (cfg_cascade != m_cq);
      ta = sw_trig_a | (ext_trig & en_ext_a) | (pwm_trig_a & en_pwma_a)
         | (cfg_cascade & pwm_trig_b & en_pwmb_casc);
      tb = !cfg_cascade & (sw_trig_b | (pwm_trig_b & en_pwmb_b));
      ca = chg | seq_rst_a;
      cb = chg | (seq_rst_b & !cfg_cascade);
      take_a = 0; take_b = 0;
      o_own = m_own;
      m_ea = 0; m_eb = 0; m_cq = cfg_cascade;
      if ((o_own == 1 && ca) || (o_own == 2 && cb)) begin
        m_own = 0; m_wait = 0;
      end else if (o_own == 0) begin
        m_wait = 0;
        if ((m_qa || ta) && !ca) begin m_own = 1; take_a = 1; end
        else if ((m_qb || tb) && !cb && !cfg_cascade) begin m_own = 2; take_b = 1; end
      end else if (!m_wait) begin
        if (req_ready) m_wait = 1;
      end else if (conv_done) begin
        if (o_own == 2) begin base = 8; last = 15; endp = 8 + max_b; p = m_pb; end
        else if (cfg_cascade) begin base = 0; last = 15; endp = max_casc; p = m_pa; end
        else begin base = 0; last = 7; endp = max_a; p = m_pa; end
        at_end = (p == endp);
        if (at_end && cfg_continuous && !cfg_override) np = base;
        else np = (p == last) ? base : p + 1;
        if (o_own == 2) begin m_pb = np; m_eb = at_end; end
        else begin m_pa = np; m_ea = at_end; end
        m_wait = 0;
        if (at_end && !cfg_continuous) m_own = 0;
      end
      m_qa = ca ? 0 : (take_a ? 0 : (m_qa | ta));
      m_qb = cb ? 0 : (take_b ? 0 : (m_qb | tb));
      if (ca) m_pa = 0;
      if (cb) m_pb = 8;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model (model R3)
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int e_slot;
      e_slot = (m_own == 2) ? m_pb : m_pa;
      n_chk++;
      if (slot_idx != e_slot || req_valid != (m_own != 0 && !m_wait) ||
          busy_a != (m_own == 1) || busy_b != (m_own == 2) ||
          eos_a != m_ea || eos_b != m_eb) begin
        n_err++;
        $display("FAIL model R3 t=%0t: actual slot=%0d req=%0d ba=%0d bb=%0d ea=%0d eb=%0d expected slot=%0d req=%0d ba=%0d bb=%0d ea=%0d eb=%0d",
                 $time, slot_idx, req_valid, busy_a, busy_b, eos_a, eos_b,
                 e_slot, (m_own != 0 && !m_wait), (m_own == 1), (m_own == 2), m_ea, m_eb);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // 0 sw_a, 1 sw_b, 2 rst_a, 3 rst_b, 4 pwm_b, 5 ext
  task automatic pulse(input int w);
    case (w)
      0: sw_trig_a = 1; 1: sw_trig_b = 1; 2: seq_rst_a = 1;
      3: seq_rst_b = 1; 4: pwm_trig_b = 1; default: ext_trig = 1;
    endcase
    @(negedge clk);
    sw_trig_a = 0; sw_trig_b = 0; seq_rst_a = 0; seq_rst_b = 0;
    pwm_trig_b = 0; ext_trig = 0;
  endtask

  task automatic wait_eos(input bit b, input string tag);
    bit seen = 0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk);
      seen = b ? eos_b : eos_a;
    end
    chk(tag, seen, 1);
  endtask

  task automatic wait_slot(input int s, input string tag);
    bit seen = 0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk);
      seen = req_valid && (slot_idx == s);
    end
    chk(tag, seen, 1);
  endtask

  task automatic wait_leave(input int s);
    for (int i = 0; i < 3000 && slot_idx == s; i++) @(negedge clk);
  endtask

  initial begin
    step(4);
    rst_n = 1;
    step(2);
    // R1 reset state
    chk("R1 slot", slot_idx, 0);   chk("R1 req", req_valid, 0);
    chk("R1 busy_a", busy_a, 0);   chk("R1 busy_b", busy_b, 0);
    chk("R1 eos", eos_a | eos_b, 0);

    // R2 / R4 start-stop on A
    pulse(0);
    chk("R2 req", req_valid, 1); chk("R2 slot A", slot_idx, 0); chk("R2 busy_a", busy_a, 1);
    wait_eos(0, "R4 eos_a");
    chk("R4 idle", busy_a, 0); chk("R4 next ptr", slot_idx, 3);
    step(1);
    chk("R4 one cycle", eos_a, 0);
    pulse(0);
    chk("R4 resume", slot_idx, 3);
    wait_eos(0, "R4 eos wrap");
    chk("R4 wrap ptr", slot_idx, 3);
    pulse(2);
    chk("R7 ptr base", slot_idx, 0);

    // B in dual mode
    pulse(1);
    chk("R2 busy_b", busy_b, 1); chk("R2 slot B", slot_idx, 8);
    wait_eos(1, "R4 eos_b");
    chk("R4 b idle", busy_b, 0);
    pulse(1);
    chk("R4 b resume", slot_idx, 10);
    step(3);
    pulse(3);
    chk("R7 b idle", busy_b, 0); chk("R7 b req", req_valid, 0);
    pulse(1);
    chk("R7 b base", slot_idx, 8);
    wait_eos(1, "R4 eos_b2");
    pulse(3);

    // R10 arbitration
    max_a = 3'd1;
    sw_trig_a = 1; sw_trig_b = 1;
    @(negedge clk);
    sw_trig_a = 0; sw_trig_b = 0;
    chk("R10 A first", busy_a, 1); chk("R10 B waits", busy_b, 0);
    wait_eos(0, "R10 eos_a");
    step(1);
    chk("R10 B granted", busy_b, 1); chk("R10 B slot", slot_idx, 8);
    wait_eos(1, "R10 eos_b");
    pulse(0);
    step(2);
    pulse(1);
    chk("R10 latched", busy_b, 0);
    wait_eos(0, "R10 eos_a2");
    step(1);
    chk("R10 pending served", busy_b, 1);
    wait_eos(1, "R10 eos_b2");
    pulse(2); pulse(3);

    // R5 continuous, wrap at max
    cfg_continuous = 1; max_a = 3'd2;
    pulse(0);
    wait_eos(0, "R5 eos");
    chk("R5 busy", busy_a, 1); chk("R5 base", slot_idx, 0); chk("R5 req", req_valid, 1);
    // R3 back-pressure
    bp = 1;
    for (int i = 0, k = 0; i < 80 && k < 5; i++) begin
      @(negedge clk);
      if (req_valid && !req_ready) begin
        int s;
        s = slot_idx;
        @(negedge clk);
        chk("R3 hold valid", req_valid, 1);
        chk("R3 hold slot", slot_idx, s);
        k++;
      end
    end
    bp = 0;
    step(2);
    pulse(2);
    chk("R7 abort", busy_a, 0); chk("R7 no req", req_valid, 0);

    // R6 override
    cfg_override = 1; max_a = 3'd1;
    pulse(0);
    wait_eos(0, "R6 eos");
    chk("R6 run on", slot_idx, 2); chk("R6 busy", busy_a, 1);
    wait_slot(7, "R6 reach 7");
    wait_leave(7);
    chk("R6 wrap A", slot_idx, 0);
    pulse(2);
    max_b = 3'd0;
    pulse(1);
    wait_slot(15, "R6 reach 15");
    wait_leave(15);
    chk("R6 wrap B", slot_idx, 8);

    // R11 mode change while B runs
    cfg_cascade = 1;
    @(negedge clk);
    chk("R11 b idle", busy_b, 0); chk("R11 no req", req_valid, 0);
    chk("R11 base", slot_idx, 0);
    step(1);

    // R8 combined sequencer
    max_casc = 4'd9;
    pulse(0);
    chk("R8 busy", busy_a, 1);
    wait_slot(15, "R8 reach 15");
    wait_leave(15);
    chk("R8 wrap", slot_idx, 0);
    pulse(3);
    chk("R8 rst_b ignored", busy_a, 1);
    pulse(2);
    chk("R8 rst_a", busy_a, 0);
    cfg_continuous = 0; cfg_override = 0; max_casc = 4'd10;
    pulse(1);
    chk("R8 sw_b ignored a", busy_a, 0); chk("R8 sw_b ignored b", busy_b, 0);
    pulse(0);
    wait_eos(0, "R8 eos");
    chk("R8 ptr", slot_idx, 11);
    pulse(2);

    // R9 routing
    en_pwmb_casc = 1;
    pulse(4);
    chk("R9 casc pwm_b", busy_a, 1);
    pulse(2);
    cfg_cascade = 0;
    step(2);
    pulse(4);
    chk("R9 dual ignore a", busy_a, 0); chk("R9 dual ignore b", busy_b, 0);
    en_ext_a = 1;
    pulse(5);
    chk("R9 ext", busy_a, 1);
    pulse(2);
    en_pwmb_b = 1;
    pulse(4);
    chk("R9 pwm_b to B", busy_b, 1);
    pulse(3);
    step(5);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule